// File: doc/BRIEF.md
# DRAM Timing and Refresh Controller

This block sits between an asynchronous 68000-style bus and a banked DRAM array. It samples the address strobe, data strobes and read/write line through synchronizers on its own clock. When a strobed address falls inside an 8 MB RAM window, it runs a row phase and then a column phase. In the row phase the selected bank's row strobe is asserted while the address multiplexer presents the row half of the address. In the column phase the multiplexer switches to the column half, the column strobes follow, and the CPU is told the cycle may complete. Every strobe is released when the address strobe goes away.

Refresh uses the column-before-row method, so the DRAMs step their own internal row counter and the controller supplies no row address. A refresh request is raised once every twelve rising edges of the slow E clock. It waits for any CPU cycle that is already running to finish. It then runs before the next cycle is granted. A CPU cycle that starts while a refresh is in progress sees the ready output held low, which adds wait states until the refresh and its precharge are done.

The bank decode handles two device sizes and a fill level. Every address in the window gets a full cycle and a ready, even when the bank it maps to is not fitted; in that case no row strobe is asserted.

Top module: `dram_ctl_top`

## Requirements
- R1: With the bus idle, successive refresh cycles begin exactly 12 E-clock periods apart.
- R2: A refresh asserts both column strobe lanes for T_CSR (default 2) cycles with all row strobes low. It then asserts all row strobes together with the column strobes for T_RAS (default 4) cycles. After that, row and column strobes drop in the same cycle, and at least T_RP (default 3) cycles pass before any row strobe rises again.
- R3: An access first asserts one bank row strobe with mux_col low. Exactly T_RCD (default 2) cycles later, mux_col rises and bus_ready is asserted. bus_ready is never high while mux_col is low.
- R4: On a read (bus_read=1), both column lanes are asserted in the column phase. On a write (bus_read=0), lane 1 follows data_strobe[1] (upper byte) and lane 0 follows data_strobe[0] (lower byte).
- R5: After addr_strobe is deasserted, bank_ras, cas_lanes, mux_col and bus_ready are all low within 4 clock cycles.
- R6: A row strobe rises only while addr_strobe is high. A byte address outside 0x200000 to 0x9FFFFF produces no row strobe, no column strobe and no ready.
- R7: With big_dev=1 (1Mx4 parts), the bank index is bits 22:21 of (address - 0x200000), so each bank covers 2 MB. bank_ras[i] belongs to bank i.
- R8: With big_dev=0 (256Kx4 parts), the bank index is bits 20:19 of the window offset, so each bank covers 512 KB. Offsets of 2 MB and above complete with ready but assert no row strobe.
- R9: fill_level codes the fitted capacity: 0 is none, 1 is 2 MB, 2 is 4 MB, 3 is 8 MB. A window address in a bank beyond the fitted capacity completes with ready and asserts no row strobe.
- R10: A refresh that falls due during an access does not interrupt it. It starts within 10 cycles after addr_strobe is released.
- R11: An access whose strobe arrives during a refresh keeps bus_ready low until the refresh has finished. It is then served in the bank it addresses.
- R12: While rst is high, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_strobe | input | 1 | Bus address strobe, active high, asynchronous |
| data_strobe | input | 2 | Byte data strobes, bit 1 upper byte, bit 0 lower byte, active high |
| bus_read | input | 1 | 1 for a read cycle, 0 for a write |
| bus_addr | input | ADDR_W-1 (23) | Bus word address, byte address bits 23:1 |
| e_clk | input | 1 | Slow E clock used as the refresh timebase |
| big_dev | input | 1 | 1 selects 1Mx4 devices, 0 selects 256Kx4 |
| fill_level | input | 2 | Fitted capacity code |
| bank_ras | output | NBANK (4) | Per-bank row strobe, active high |
| cas_lanes | output | 2 | Column strobes per byte lane, active high |
| mux_col | output | 1 | Address multiplexer select, 1 is column half |
| bus_ready | output | 1 | Cycle may complete, active high |

## Verification
The checks on strobe ordering assume that addr_strobe stays high for several controller cycles and that the address and read/write line are stable for the whole time the strobe is high. Under those conditions a row strobe can only rise while the raw strobe is still asserted. The stimulus changes inputs only on falling clock edges, holds every strobe until ready is seen or a bounded wait has passed, and never changes the address mid-cycle. The tests that depend on refresh timing first align themselves to the end of a refresh, so that each group of accesses fits inside one refresh interval.

// File: rtl/dram_ctl_pkg.sv
package dram_ctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_REF_CAS,
    ST_REF_RAS,
    ST_PRE
  } seq_state_t;
endpackage

// File: rtl/dram_sync.sv
module dram_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int DIV    = 12,
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic e_clk,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          e_s;
  logic          e_prev;
  logic [CW-1:0] cnt;
  logic          e_rise;

  dram_sync #(.W(1), .STAGES(STAGES)) u_esync (
    .clk(clk), .rst(rst), .d(e_clk), .q(e_s)
  );

  assign e_rise = e_s & ~e_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      e_prev <= 1'b0;
      cnt    <= '0;
      tick   <= 1'b0;
    end else begin
      e_prev <= e_s;
      tick   <= 1'b0;
      if (e_rise) begin
        if (cnt == CW'(DIV - 1)) begin
          cnt  <= '0;
          tick <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dram_bank_decode.sv
module dram_bank_decode #(
  parameter int          ADDR_W      = 24,
  parameter logic [31:0] WIN_BASE    = 32'h0020_0000,
  parameter int          WIN_LOG2    = 23,
  parameter int          NBANK       = 4,
  parameter int          BIG_SHIFT   = 21,
  parameter int          SMALL_SHIFT = 19
) (
  input  logic [ADDR_W-1:1] addr,
  input  logic              big_dev,
  input  logic [1:0]        fill,
  output logic              hit,
  output logic [NBANK-1:0]  sel
);
  localparam logic [31:0] WIN_BYTES = 32'd1 << WIN_LOG2;
  localparam logic [31:0] UNIT_2M   = 32'd2 << 20;

  logic [31:0] byte_a;
  logic [31:0] offset;
  logic [31:0] bank_idx;
  logic [31:0] fill_bytes;
  logic [31:0] banks_fit;
  logic [4:0]  shamt;

  always_comb begin
    byte_a     = 32'({addr, 1'b0});
    hit        = (byte_a >= WIN_BASE) && (byte_a < WIN_BASE + WIN_BYTES);
    offset     = byte_a - WIN_BASE;
    shamt      = big_dev ? 5'(BIG_SHIFT) : 5'(SMALL_SHIFT);
    bank_idx   = offset >> shamt;
    fill_bytes = (fill == 2'd0) ? 32'd0 : (UNIT_2M << (fill - 2'd1));
    banks_fit  = fill_bytes >> shamt;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign sel[b] = hit && (bank_idx == 32'(b)) && (32'(b) < banks_fit);
  end
endmodule

// File: rtl/dram_sequencer.sv
module dram_sequencer
  import dram_ctl_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int T_RCD = 2,
  parameter int T_CSR = 2,
  parameter int T_RAS = 4,
  parameter int T_RP  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             as_s,
  input  logic             wr_s,
  input  logic [1:0]       strb_s,
  input  logic             hit,
  input  logic [NBANK-1:0] sel,
  output logic [NBANK-1:0] bank_ras,
  output logic [1:0]       cas_lanes,
  output logic             mux_col,
  output logic             bus_ready
);
  localparam int TMAX1 = (T_RCD > T_CSR) ? T_RCD : T_CSR;
  localparam int TMAX2 = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
  localparam int CNT_W = $clog2(TMAX + 1);

  seq_state_t       st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [NBANK-1:0] sel_q, sel_n;
  logic             wr_q, wr_n;
  logic             pend, pend_n;
  logic [NBANK-1:0] ras_n;
  logic [1:0]       cas_n;
  logic             col_n, rdy_n;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    sel_n  = sel_q;
    wr_n   = wr_q;
    pend_n = pend | ref_tick;
    unique case (st)
      ST_IDLE: begin
        if (pend) begin
          st_n   = ST_REF_CAS;
          cnt_n  = CNT_W'(T_CSR - 1);
          pend_n = ref_tick;
        end else if (as_s && hit) begin
          st_n  = ST_ROW;
          cnt_n = CNT_W'(T_RCD - 1);
          sel_n = sel;
          wr_n  = wr_s;
        end
      end
      ST_ROW: begin
        if (!as_s) begin
          st_n  = ST_PRE;
          cnt_n = CNT_W'(T_RP - 1);
        end else if (cnt == '0) begin
          st_n = ST_COL;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_COL: begin
        if (!as_s) begin
          st_n  = ST_PRE;
          cnt_n = CNT_W'(T_RP - 1);
        end
      end
      ST_REF_CAS: begin
        if (cnt == '0) begin
          st_n  = ST_REF_RAS;
          cnt_n = CNT_W'(T_RAS - 1);
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_REF_RAS: begin
        if (cnt == '0) begin
          st_n  = ST_PRE;
          cnt_n = CNT_W'(T_RP - 1);
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_PRE: begin
        if (cnt == '0) st_n = ST_IDLE;
        else           cnt_n = cnt - 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase

    ras_n = '0;
    cas_n = '0;
    col_n = 1'b0;
    rdy_n = 1'b0;
    unique case (st_n)
      ST_ROW: ras_n = sel_n;
      ST_COL: begin
        ras_n = sel_n;
        col_n = 1'b1;
        rdy_n = 1'b1;
        cas_n = wr_n ? strb_s : 2'b11;
      end
      ST_REF_CAS: cas_n = 2'b11;
      ST_REF_RAS: begin
        cas_n = 2'b11;
        ras_n = '1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sel_q     <= '0;
      wr_q      <= 1'b0;
      pend      <= 1'b0;
      bank_ras  <= '0;
      cas_lanes <= '0;
      mux_col   <= 1'b0;
      bus_ready <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      sel_q     <= sel_n;
      wr_q      <= wr_n;
      pend      <= pend_n;
      bank_ras  <= ras_n;
      cas_lanes <= cas_n;
      mux_col   <= col_n;
      bus_ready <= rdy_n;
    end
  end
endmodule

// File: rtl/dram_ctl_top.sv
module dram_ctl_top #(
  parameter int ADDR_W   = 24,
  parameter int NBANK    = 4,
  parameter int SYNC_N   = 2,
  parameter int REF_DIV  = 12,
  parameter int T_RCD    = 2,
  parameter int T_CSR    = 2,
  parameter int T_RAS    = 4,
  parameter int T_RP     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_strobe,
  input  logic [1:0]        data_strobe,
  input  logic              bus_read,
  input  logic [ADDR_W-1:1] bus_addr,
  input  logic              e_clk,
  input  logic              big_dev,
  input  logic [1:0]        fill_level,
  output logic [NBANK-1:0]  bank_ras,
  output logic [1:0]        cas_lanes,
  output logic              mux_col,
  output logic              bus_ready
);
  logic [3:0]       bus_s;
  logic             ref_tick;
  logic             hit;
  logic [NBANK-1:0] sel;

  dram_sync #(.W(4), .STAGES(SYNC_N)) u_bsync (
    .clk(clk), .rst(rst),
    .d({addr_strobe, ~bus_read, data_strobe}),
    .q(bus_s)
  );

  dram_refresh_timer #(.DIV(REF_DIV), .STAGES(SYNC_N)) u_timer (
    .clk(clk), .rst(rst), .e_clk(e_clk), .tick(ref_tick)
  );

  dram_bank_decode #(.ADDR_W(ADDR_W), .NBANK(NBANK)) u_dec (
    .addr(bus_addr), .big_dev(big_dev), .fill(fill_level),
    .hit(hit), .sel(sel)
  );

  dram_sequencer #(
    .NBANK(NBANK), .T_RCD(T_RCD), .T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)
  ) u_seq (
    .clk(clk), .rst(rst), .ref_tick(ref_tick),
    .as_s(bus_s[3]), .wr_s(bus_s[2]), .strb_s(bus_s[1:0]),
    .hit(hit), .sel(sel),
    .bank_ras(bank_ras), .cas_lanes(cas_lanes),
    .mux_col(mux_col), .bus_ready(bus_ready)
  );
endmodule

// File: rtl/dram_ctl_checker.sv
module dram_ctl_checker #(
  parameter int NBANK = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             addr_strobe,
  input logic [NBANK-1:0] bank_ras,
  input logic [1:0]       cas_lanes,
  input logic             mux_col,
  input logic             bus_ready
);
  p_cas_first_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(&bank_ras) |-> $past(&cas_lanes));

  p_ready_col_r3: assert property (@(posedge clk) disable iff (rst)
    bus_ready |-> mux_col);

  p_row_phase_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(|bank_ras) && !(&bank_ras)) |-> !mux_col);

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(mux_col) |-> (bank_ras == '0 && cas_lanes == 2'b00 && !bus_ready));

  p_ras_needs_as_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(|bank_ras) && !(&bank_ras)) |-> addr_strobe);

  p_one_bank_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_ras) || (&bank_ras));

  p_no_ready_refresh_r11: assert property (@(posedge clk) disable iff (rst)
    (&bank_ras) |-> !bus_ready);
endmodule

bind dram_ctl_top dram_ctl_checker #(.NBANK(NBANK)) u_chk (
  .clk(clk), .rst(rst), .addr_strobe(addr_strobe),
  .bank_ras(bank_ras), .cas_lanes(cas_lanes),
  .mux_col(mux_col), .bus_ready(bus_ready)
);

// File: tb/sim_dram_ctl_top.sv
module sim_dram_ctl_top;
  localparam int T_RCD = 2;
  localparam int T_CSR = 2;
  localparam int T_RAS = 4;
  localparam int T_RP  = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr_strobe = 1'b0;
  logic [1:0]  data_strobe = 2'b00;
  logic        bus_read = 1'b1;
  logic [23:1] bus_addr = '0;
  logic        e_clk = 1'b0;
  logic        big_dev = 1'b1;
  logic [1:0]  fill_level = 2'd3;
  logic [3:0]  bank_ras;
  logic [1:0]  cas_lanes;
  logic        mux_col;
  logic        bus_ready;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  dram_ctl_top u0 (
    .clk(clk), .rst(rst), .addr_strobe(addr_strobe), .data_strobe(data_strobe),
    .bus_read(bus_read), .bus_addr(bus_addr), .e_clk(e_clk), .big_dev(big_dev),
    .fill_level(fill_level), .bank_ras(bank_ras), .cas_lanes(cas_lanes),
    .mux_col(mux_col), .bus_ready(bus_ready)
  );

  always #10 clk = ~clk;
  always #200 e_clk = ~e_clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit in_refresh();
    return (cas_lanes == 2'b11) && (bank_ras == 4'b0000 || bank_ras == 4'b1111);
  endfunction

  task automatic wait_ref_start(output int t);
    t = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (cas_lanes == 2'b11 && bank_ras == 4'b0000 && !mux_col) begin
        t = cyc;
        break;
      end
    end
  endtask

  task automatic wait_ref_end();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (cas_lanes == 2'b00 && bank_ras == 4'b0000) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic align();
    int t;
    wait_ref_start(t);
    wait_ref_end();
  endtask

  task automatic access(input logic [23:0] a, input bit rd, input logic [1:0] strb,
                        output bit rdy, output logic [3:0] ras_at,
                        output logic [1:0] cas_at, output int rcd,
                        output int rel, output bit any_strobe);
    int t_ras;
    t_ras = -1;
    rdy = 0; ras_at = '0; cas_at = '0; rcd = -1; rel = -1; any_strobe = 0;
    @(negedge clk);
    bus_addr = a[23:1];
    bus_read = rd;
    data_strobe = strb;
    addr_strobe = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (bank_ras != 0 || cas_lanes != 0) any_strobe = 1;
      if (bank_ras != 0 && t_ras < 0) t_ras = cyc;
      if (bus_ready) begin
        rdy = 1;
        ras_at = bank_ras;
        cas_at = cas_lanes;
        if (t_ras >= 0) rcd = cyc - t_ras;
        break;
      end
    end
    addr_strobe = 1'b0;
    data_strobe = 2'b00;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (bank_ras == 0 && cas_lanes == 0 && !mux_col && !bus_ready) begin
        rel = i;
        break;
      end
    end
    repeat (T_RP + 2) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(bank_ras == 0 && cas_lanes == 0 && !mux_col && !bus_ready, "R12 reset outputs",
          {bank_ras, cas_lanes, mux_col, bus_ready}, 0);
    rst = 1'b0;
  endtask

  task automatic t_refresh();
    int t0, t1, n;
    wait_ref_start(t0);
    check(t0 >= 0, "R1 first refresh seen", t0, 0);
    n = 0;
    while (bank_ras != 4'b1111 && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == T_CSR, "R2 column lead before row", n, T_CSR);
    n = 0;
    while (bank_ras == 4'b1111 && cas_lanes == 2'b11 && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == T_RAS, "R2 row strobe width", n, T_RAS);
    check(bank_ras == 0 && cas_lanes == 0, "R2 joint release",
          {bank_ras, cas_lanes}, 0);
    wait_ref_start(t1);
    check(t1 - t0 == 240, "R1 refresh spacing", t1 - t0, 240);
    wait_ref_end();
  endtask

  task automatic t_big();
    bit rdy, anys; logic [3:0] r; logic [1:0] c; int rcd, rel;
    big_dev = 1'b1; fill_level = 2'd3;
    align();
    access(24'h200000, 1'b1, 2'b11, rdy, r, c, rcd, rel, anys);
    check(rdy && r == 4'b0001, "R7 bank0 at 0x200000", r, 1);
    check(rcd == T_RCD, "R3 row to column delay", rcd, T_RCD);
    check(rel >= 1 && rel <= 4, "R5 release after strobe", rel, 3);
    access(24'h400000, 1'b0, 2'b10, rdy, r, c, rcd, rel, anys);
    check(rdy && r == 4'b0010, "R7 bank1 at 0x400000", r, 2);
    check(c == 2'b10, "R4 write upper lane only", c, 2);
    access(24'h9FFFFE, 1'b1, 2'b01, rdy, r, c, rcd, rel, anys);
    check(rdy && r == 4'b1000, "R7 bank3 at top of window", r, 8);
    check(c == 2'b11, "R4 read both lanes", c, 3);
    access(24'h600002, 1'b0, 2'b01, rdy, r, c, rcd, rel, anys);
    check(rdy && r == 4'b0100 && c == 2'b01, "R4 write lower lane bank2",
          {r, c}, {4'b0100, 2'b01});
  endtask

  task automatic t_outside();
    bit rdy, anys; logic [3:0] r; logic [1:0] c; int rcd, rel;
    big_dev = 1'b1; fill_level = 2'd3;
    align();
    access(24'hA00000, 1'b1, 2'b11, rdy, r, c, rcd, rel, anys);
    check(!rdy && !anys, "R6 above window ignored", {rdy, anys}, 0);
    access(24'h1FFFFE, 1'b1, 2'b11, rdy, r, c, rcd, rel, anys);
    check(!rdy && !anys, "R6 below window ignored", {rdy, anys}, 0);
  endtask

  task automatic t_small_fill();
    bit rdy, anys; logic [3:0] r; logic [1:0] c; int rcd, rel;
    big_dev = 1'b0; fill_level = 2'd1;
    align();
    access(24'h280000, 1'b1, 2'b11, rdy, r, c, rcd, rel, anys);
    check(rdy && r == 4'b0010, "R8 small bank1 at 0x280000", r, 2);
    access(24'h400000, 1'b1, 2'b11, rdy, r, c, rcd, rel, anys);
    check(rdy && r == 4'b0000, "R8 small beyond 2MB no row", {rdy, r}, 16);
    big_dev = 1'b1; fill_level = 2'd1;
    access(24'h200000, 1'b1, 2'b11, rdy, r, c, rcd, rel, anys);
    check(rdy && r == 4'b0001, "R9 fill 2MB bank0 fitted", r, 1);
    access(24'h400000, 1'b1, 2'b11, rdy, r, c, rcd, rel, anys);
    check(rdy && r == 4'b0000, "R9 fill 2MB bank1 absent", {rdy, r}, 16);
    fill_level = 2'd0;
    access(24'h200000, 1'b1, 2'b11, rdy, r, c, rcd, rel, anys);
    check(rdy && r == 4'b0000, "R9 fill none still ready", {rdy, r}, 16);
    fill_level = 2'd3;
  endtask

  task automatic t_hold();
    bit lost, seen;
    int n;
    big_dev = 1'b1; fill_level = 2'd3;
    align();
    @(negedge clk);
    bus_addr = 23'h100000; bus_read = 1'b1; data_strobe = 2'b11; addr_strobe = 1'b1;
    repeat (8) @(negedge clk);
    lost = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!bus_ready || bank_ras != 4'b0001) lost = 1;
    end
    check(!lost, "R10 held access not interrupted", lost, 0);
    addr_strobe = 1'b0; data_strobe = 2'b00;
    seen = 0; n = 0;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk);
      if (cas_lanes == 2'b11 && bank_ras == 4'b0000) begin
        seen = 1; n = i; break;
      end
    end
    check(seen, "R10 deferred refresh runs after release", n, 7);
    wait_ref_end();
  endtask

  task automatic t_collide();
    int t, t_rel, t_acc;
    bit bad_rdy, rdy;
    logic [3:0] r;
    big_dev = 1'b1; fill_level = 2'd3;
    wait_ref_start(t);
    bus_addr = 23'h100000; bus_read = 1'b1; data_strobe = 2'b11; addr_strobe = 1'b1;
    bad_rdy = 0; rdy = 0; t_rel = -1; t_acc = -1; r = '0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (in_refresh() && bus_ready) bad_rdy = 1;
      if (t_rel < 0 && bank_ras == 0 && cas_lanes == 0) t_rel = cyc;
      if (t_acc < 0 && bank_ras != 0 && bank_ras != 4'b1111) t_acc = cyc;
      if (bus_ready) begin
        rdy = 1; r = bank_ras; break;
      end
    end
    check(!bad_rdy, "R11 ready held during refresh", bad_rdy, 0);
    check(rdy && r == 4'b0001, "R11 access served after refresh", {rdy, r}, 17);
    check(t_rel >= 0 && t_acc - t_rel >= T_RP, "R2 precharge before access",
          t_acc - t_rel, T_RP + 1);
    addr_strobe = 1'b0; data_strobe = 2'b00;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_refresh();
    t_big();
    t_outside();
    t_small_fill();
    t_hold();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule